// File: doc/BRIEF.md
# Stream Line-Framing Parameter Calculator

This block turns a video mode into three values that the per-stream framing logic of a multi-lane link transmitter needs. A one-cycle strobe supplies the active pixel count per line, the colour depth in bits per pixel, the lane count, the colour format, the transfer-unit length and the minimum byte count per transfer unit. From these it derives three results. The first is the number of 16-bit datapath words one line occupies. The second is the per-lane word count value loaded into the framing counters. The third is the number of wait cycles the framer inserts at the start of each line so that its input buffer can fill.

The pixel-by-depth product is formed by a shift-add multiplier that takes one cycle per depth bit. The divide-by-three needed for luma-only video runs in a restoring divider at the same time. A busy flag covers the whole calculation, and a single-cycle done pulse marks the cycle in which all three results become valid. The results then hold until the next accepted strobe completes. A lane count other than 1, 2 or 4 is rejected: the block flags an error, returns zeros and still gives a done pulse.

Top module: `dpcfg_calc`

## Requirements
- R1: `words_per_line` equals ceil(`pix_count` × `bits_pp` / 16), which is 0 when either operand is 0.
- R2: With `lane_cnt` = 1, `lane_word_count` equals `words_per_line` − 1. It saturates to 0 when `words_per_line` is 0.
- R3: With `lane_cnt` = N (2 or 4) and `words_per_line` a multiple of N, `lane_word_count` equals `words_per_line` − N, saturated to 0.
- R4: With `lane_cnt` = N (2 or 4) and `words_per_line` not a multiple of N, `lane_word_count` equals `words_per_line` + (`words_per_line` mod N) − N, saturated to 0.
- R5: When `tu_min_bytes` ≤ 4, `line_wait` is 64 whatever the colour format.
- R6: When `tu_min_bytes` > 4 and `color_fmt` is 0 (RGB / 4:4:4) or 3 (treated as 4:4:4), `line_wait` = `tu_len` − `tu_min_bytes`. The value is 0 if `tu_min_bytes` ≥ `tu_len`.
- R7: When `tu_min_bytes` > 4 and `color_fmt` is 1 (4:2:2), `line_wait` is the R6 difference divided by 2, rounded down.
- R8: When `tu_min_bytes` > 4 and `color_fmt` is 2 (luma only), `line_wait` is the R6 difference divided by 3, rounded down.
- R9: A start with `lane_cnt` not in {1, 2, 4} gives `lane_err` = 1 and zero on all three results in its done cycle. The next valid run clears `lane_err`.
- R10: A start is accepted only when `busy` is low. `busy` rises in the cycle after acceptance and stays high through the done cycle. A start seen while `busy` is high, the done cycle included, has no effect.
- R11: Each accepted start produces exactly one `done` pulse, one cycle long.
- R12: After reset `busy`, `done`, `lane_err` and all three results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| pix_count | input | 16 | Active pixels per line |
| bits_pp | input | 6 | Bits per pixel |
| lane_cnt | input | 3 | Lane count (1, 2 or 4) |
| color_fmt | input | 2 | 0 RGB/4:4:4, 1 4:2:2, 2 luma only, 3 as 4:4:4 |
| tu_len | input | 7 | Transfer-unit length in bytes |
| tu_min_bytes | input | 8 | Minimum bytes per transfer unit |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| lane_err | output | 1 | Last request had an illegal lane count |
| words_per_line | output | 18 | 16-bit words per line |
| lane_word_count | output | 18 | Per-lane word count value |
| line_wait | output | 8 | Start-of-line wait cycles |

## Verification
The two events that can share a cycle are the done pulse of one calculation and the start strobe of the next. The bench raises `start` with new operands in exactly the cycle where `done` is high. It then checks one cycle later that `busy` and `done` are low and that the three results still hold the values of the finished run, so the late request was dropped rather than queued. An illegal lane count makes acceptance and completion fall one cycle apart. The bench checks that the done pulse of such a request arrives with the error flag and with zeroed results.

// File: rtl/dpcfg_pkg.sv
package dpcfg_pkg;

    localparam int PIX_W   = 16;
    localparam int BPP_W   = 6;
    localparam int LANE_W  = 3;
    localparam int TU_W    = 7;
    localparam int MINB_W  = 8;
    localparam int WAIT_W  = 8;
    localparam int WORD_B  = 16;                    // internal word width in bits
    localparam int SHIFT_W = $clog2(WORD_B);
    localparam int PROD_W  = PIX_W + BPP_W;
    localparam int WORD_W  = PROD_W - SHIFT_W;
    localparam int MINB_LOW   = 4;
    localparam int WAIT_FIXED = 64;
    localparam int LUMA_DIV   = 3;

    typedef enum logic [1:0] {
        CF_FULL = 2'd0,
        CF_HALF = 2'd1,
        CF_LUMA = 2'd2,
        CF_RSVD = 2'd3
    } cfmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_st_e;

    typedef struct packed {
        logic [LANE_W-1:0] lanes;
        cfmt_e             fmt;
        logic              low_min;
    } cap_t;

    typedef struct packed {
        logic [WORD_W-1:0] words;
        logic [WORD_W-1:0] per_lane;
        logic [WAIT_W-1:0] wait_cyc;
    } result_t;

    function automatic logic lanes_legal(input logic [LANE_W-1:0] n);
        return (n == LANE_W'(1)) || (n == LANE_W'(2)) || (n == LANE_W'(4));
    endfunction

    function automatic logic [WORD_W-1:0] words_from_prod(input logic [PROD_W-1:0] p);
        return WORD_W'(p[PROD_W-1:SHIFT_W]) + WORD_W'(|p[SHIFT_W-1:0]);
    endfunction

    // one formula covers every lane count: the remainder is zero for one lane
    function automatic logic [WORD_W-1:0] lane_round(input logic [WORD_W-1:0] w,
                                                     input logic [LANE_W-1:0] n);
        logic [WORD_W:0] rem;
        logic [WORD_W:0] sum;
        logic [WORD_W:0] nn;
        rem = {1'b0, w & WORD_W'(n - LANE_W'(1))};
        sum = {1'b0, w} + rem;
        nn  = (WORD_W+1)'(n);
        if (sum < nn) return '0;
        return WORD_W'(sum - nn);
    endfunction

    function automatic logic [WAIT_W-1:0] tu_slack(input logic [TU_W-1:0]   tu,
                                                   input logic [MINB_W-1:0] mb);
        if (mb >= MINB_W'(tu)) return '0;
        return WAIT_W'(MINB_W'(tu) - mb);
    endfunction

endpackage

// File: rtl/dpcfg_mul.sv
module dpcfg_mul #(
    parameter int A_W = 16,
    parameter int B_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic               run,
    output logic [A_W+B_W-1:0] prod
);
    localparam int P_W   = A_W + B_W;
    localparam int CNT_W = $clog2(B_W + 1);

    logic [P_W-1:0]   mcand;
    logic [B_W-1:0]   mplier;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            prod   <= '0;
            mcand  <= '0;
            mplier <= '0;
            cnt    <= '0;
        end else if (go) begin
            run    <= 1'b1;
            prod   <= '0;
            mcand  <= P_W'(a);
            mplier <= b;
            cnt    <= CNT_W'(B_W);
        end else if (run) begin
            if (mplier[0]) prod <= prod + mcand;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt - CNT_W'(1);
            run    <= (cnt != CNT_W'(1));
        end
    end
endmodule

// File: rtl/dpcfg_div.sv
module dpcfg_div #(
    parameter int N_W     = 8,
    parameter int DIVISOR = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [N_W-1:0] dvd,
    output logic           run,
    output logic [N_W-1:0] quo
);
    localparam int R_W   = $clog2(DIVISOR + 1);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [R_W-1:0]   rem;
    logic [CNT_W-1:0] cnt;
    logic [R_W:0]     trial;
    logic             qbit;

    always_comb begin
        trial = {rem, quo[N_W-1]};
        qbit  = (trial >= (R_W+1)'(DIVISOR));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            rem <= '0;
            quo <= '0;
            cnt <= '0;
        end else if (go) begin
            run <= 1'b1;
            rem <= '0;
            quo <= dvd;
            cnt <= CNT_W'(N_W);
        end else if (run) begin
            rem <= qbit ? R_W'(trial - (R_W+1)'(DIVISOR)) : R_W'(trial);
            quo <= {quo[N_W-2:0], qbit};
            cnt <= cnt - CNT_W'(1);
            run <= (cnt != CNT_W'(1));
        end
    end
endmodule

// File: rtl/dpcfg_wait_sel.sv
module dpcfg_wait_sel
    import dpcfg_pkg::*;
(
    input  logic              low_min,
    input  cfmt_e             fmt,
    input  logic [WAIT_W-1:0] slack,
    input  logic [WAIT_W-1:0] slack_div3,
    output logic [WAIT_W-1:0] wait_cyc
);
    always_comb begin
        if (low_min) begin
            wait_cyc = WAIT_W'(WAIT_FIXED);
        end else begin
            unique case (fmt)
                CF_HALF: wait_cyc = slack >> 1;
                CF_LUMA: wait_cyc = slack_div3;
                default: wait_cyc = slack;
            endcase
        end
    end
endmodule

// File: rtl/dpcfg_calc.sv
module dpcfg_calc
    import dpcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PIX_W-1:0]  pix_count,
    input  logic [BPP_W-1:0]  bits_pp,
    input  logic [LANE_W-1:0] lane_cnt,
    input  logic [1:0]        color_fmt,
    input  logic [TU_W-1:0]   tu_len,
    input  logic [MINB_W-1:0] tu_min_bytes,
    output logic              busy,
    output logic              done,
    output logic              lane_err,
    output logic [WORD_W-1:0] words_per_line,
    output logic [WORD_W-1:0] lane_word_count,
    output logic [WAIT_W-1:0] line_wait
);
    ctl_st_e           state;
    cap_t              cap;
    logic [WAIT_W-1:0] slack_q;
    result_t           res_q;
    result_t           res_next;

    logic              accept;
    logic              go;
    logic              mul_run;
    logic              div_run;
    logic [PROD_W-1:0] prod;
    logic [WAIT_W-1:0] slack_div3;
    logic [WAIT_W-1:0] wait_sel;

    assign accept = start && (state == ST_IDLE);
    assign go     = accept && lanes_legal(lane_cnt);

    dpcfg_mul #(.A_W(PIX_W), .B_W(BPP_W)) i_mul (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .a    (pix_count),
        .b    (bits_pp),
        .run  (mul_run),
        .prod (prod)
    );

    dpcfg_div #(.N_W(WAIT_W), .DIVISOR(LUMA_DIV)) i_div (
        .clk (clk),
        .rst (rst),
        .go  (go),
        .dvd (tu_slack(tu_len, tu_min_bytes)),
        .run (div_run),
        .quo (slack_div3)
    );

    dpcfg_wait_sel i_wait (
        .low_min    (cap.low_min),
        .fmt        (cap.fmt),
        .slack      (slack_q),
        .slack_div3 (slack_div3),
        .wait_cyc   (wait_sel)
    );

    always_comb begin
        res_next.words    = words_from_prod(prod);
        res_next.per_lane = lane_round(res_next.words, cap.lanes);
        res_next.wait_cyc = wait_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cap      <= '0;
            slack_q  <= '0;
            res_q    <= '0;
            done     <= 1'b0;
            lane_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cap.lanes   <= lane_cnt;
                        cap.fmt     <= cfmt_e'(color_fmt);
                        cap.low_min <= (tu_min_bytes <= MINB_W'(MINB_LOW));
                        slack_q     <= tu_slack(tu_len, tu_min_bytes);
                        if (lanes_legal(lane_cnt)) begin
                            lane_err <= 1'b0;
                            state    <= ST_RUN;
                        end else begin
                            lane_err <= 1'b1;
                            res_q    <= '0;
                            done     <= 1'b1;
                            state    <= ST_DONE;
                        end
                    end
                end
                ST_RUN: begin
                    if (!mul_run && !div_run) begin
                        res_q <= res_next;
                        done  <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy            = (state != ST_IDLE);
    assign words_per_line  = res_q.words;
    assign lane_word_count = res_q.per_lane;
    assign line_wait       = res_q.wait_cyc;
endmodule

// File: rtl/dpcfg_calc_chk.sv
module dpcfg_calc_chk
    import dpcfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [LANE_W-1:0] lane_cnt,
    input logic [1:0]        color_fmt,
    input logic [MINB_W-1:0] tu_min_bytes,
    input logic              busy,
    input logic              done,
    input logic              lane_err,
    input logic [WORD_W-1:0] words_per_line,
    input logic [WORD_W-1:0] lane_word_count,
    input logic [WAIT_W-1:0] line_wait
);
    logic [LANE_W-1:0] c_lanes;
    logic [1:0]        c_fmt;
    logic [MINB_W-1:0] c_min;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_lanes <= '0;
            c_fmt   <= '0;
            c_min   <= '0;
        end else if (start && !busy) begin
            c_lanes <= lane_cnt;
            c_fmt   <= color_fmt;
            c_min   <= tu_min_bytes;
        end
    end

    // R11
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && lane_err) |-> (words_per_line == '0 && lane_word_count == '0 && line_wait == '0));

    // R5
    low_min_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !lane_err && c_min <= MINB_W'(MINB_LOW)) |-> (line_wait == WAIT_W'(WAIT_FIXED)));

    // R2
    one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !lane_err && c_lanes == LANE_W'(1)) |->
        (lane_word_count == ((words_per_line == '0) ? '0 : words_per_line - WORD_W'(1))));

    // R4
    per_lane_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !lane_err) |-> (lane_word_count <= words_per_line));

    // R7
    half_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !lane_err && c_fmt == 2'd1 && c_min > MINB_W'(MINB_LOW)) |->
        (line_wait < WAIT_W'(WAIT_FIXED)));
endmodule

bind dpcfg_calc dpcfg_calc_chk i_chk (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .lane_cnt        (lane_cnt),
    .color_fmt       (color_fmt),
    .tu_min_bytes    (tu_min_bytes),
    .busy            (busy),
    .done            (done),
    .lane_err        (lane_err),
    .words_per_line  (words_per_line),
    .lane_word_count (lane_word_count),
    .line_wait       (line_wait)
);

// File: tb/test_dpcfg_calc.sv
`timescale 1ns/1ps
module test_dpcfg_calc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pix_count = '0;
    logic [5:0]  bits_pp = '0;
    logic [2:0]  lane_cnt = 3'd1;
    logic [1:0]  color_fmt = '0;
    logic [6:0]  tu_len = '0;
    logic [7:0]  tu_min_bytes = '0;
    logic        busy, done, lane_err;
    logic [17:0] words_per_line, lane_word_count;
    logic [7:0]  line_wait;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dpcfg_calc i_dpcfg_calc (
        .clk(clk), .rst(rst), .start(start), .pix_count(pix_count),
        .bits_pp(bits_pp), .lane_cnt(lane_cnt), .color_fmt(color_fmt),
        .tu_len(tu_len), .tu_min_bytes(tu_min_bytes), .busy(busy), .done(done),
        .lane_err(lane_err), .words_per_line(words_per_line),
        .lane_word_count(lane_word_count), .line_wait(line_wait)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    function automatic int exp_words(int p, int b);
        return (p * b + 15) / 16;
    endfunction

    function automatic int exp_lane(int w, int n);
        int t;
        t = w + (w % n) - n;
        return (t < 0) ? 0 : t;
    endfunction

    function automatic int exp_wait(int f, int t, int m);
        int d;
        if (m <= 4) return 64;
        d = (t > m) ? t - m : 0;
        if (f == 1) return d / 2;
        if (f == 2) return d / 3;
        return d;
    endfunction

    // issue one request and wait for its done pulse; leaves time at #1 after the done edge
    task automatic issue(input int p, input int b, input int l, input int f,
                         input int t, input int m, output bit ok);
        int n;
        @(posedge clk); #1;
        pix_count = 16'(p); bits_pp = 6'(b); lane_cnt = 3'(l);
        color_fmt = 2'(f); tu_len = 7'(t); tu_min_bytes = 8'(m);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        n = 0;
        while (!done && n < 100) begin
            @(posedge clk); #1;
            n++;
        end
        ok = done;
        chk(done == 1'b1, "R11 done arrives", done, 1);
    endtask

    task automatic run_check(input int p, input int b, input int l, input int f,
                             input int t, input int m, input bit chk_words);
        bit ok;
        int w;
        issue(p, b, l, f, t, m, ok);
        if (ok) begin
            w = exp_words(p, b);
            chk(lane_err == 1'b0, "R9 no error on legal lanes", lane_err, 0);
            if (chk_words) begin
                chk(words_per_line == 18'(w), "R1 words per line", words_per_line, w);
                if (l == 1)
                    chk(lane_word_count == 18'(exp_lane(w, 1)), "R2 one lane count", lane_word_count, exp_lane(w, 1));
                else if (w % l == 0)
                    chk(lane_word_count == 18'(exp_lane(w, l)), "R3 multiple lane count", lane_word_count, exp_lane(w, l));
                else
                    chk(lane_word_count == 18'(exp_lane(w, l)), "R4 remainder lane count", lane_word_count, exp_lane(w, l));
            end else begin
                if (m <= 4)      chk(line_wait == 8'(exp_wait(f, t, m)), "R5 fixed wait", line_wait, exp_wait(f, t, m));
                else if (f == 1) chk(line_wait == 8'(exp_wait(f, t, m)), "R7 half wait", line_wait, exp_wait(f, t, m));
                else if (f == 2) chk(line_wait == 8'(exp_wait(f, t, m)), "R8 third wait", line_wait, exp_wait(f, t, m));
                else             chk(line_wait == 8'(exp_wait(f, t, m)), "R6 full wait", line_wait, exp_wait(f, t, m));
            end
        end
        @(posedge clk); #1;
        chk(done == 1'b0, "R11 done one cycle", done, 0);
        chk(busy == 1'b0, "R10 idle after done", busy, 0);
    endtask

    initial begin
        int pix_set[13] = '{0, 1, 2, 3, 5, 7, 8, 15, 16, 17, 640, 1919, 65535};
        int bpp_set[8]  = '{0, 1, 8, 18, 24, 30, 48, 63};
        int lane_set[3] = '{1, 2, 4};
        int tu_set[4]   = '{32, 48, 64, 127};
        int bad_set[5]  = '{0, 3, 5, 6, 7};
        bit ok;
        int hw, hl, hwt;

        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk(busy == 0 && done == 0 && lane_err == 0, "R12 reset flags", {busy, done, lane_err}, 0);
        chk(words_per_line == 0 && lane_word_count == 0 && line_wait == 0, "R12 reset results",
            words_per_line + lane_word_count + line_wait, 0);
        rst = 1'b0;

        foreach (pix_set[i])
            foreach (bpp_set[j])
                foreach (lane_set[k])
                    run_check(pix_set[i], bpp_set[j], lane_set[k], 0, 64, 40, 1'b1);

        foreach (tu_set[i])
            for (int f = 0; f < 4; f++)
                for (int m = 0; m <= 130; m++)
                    run_check(100, 24, 2, f, tu_set[i], m, 1'b0);

        // R9 illegal lane counts
        foreach (bad_set[i]) begin
            issue(300, 24, bad_set[i], 0, 64, 20, ok);
            chk(lane_err == 1'b1, "R9 error flag", lane_err, 1);
            chk(words_per_line == 0 && lane_word_count == 0 && line_wait == 0, "R9 zero results",
                words_per_line + lane_word_count + line_wait, 0);
            @(posedge clk); #1;
            chk(done == 1'b0, "R11 error done one cycle", done, 0);
        end
        run_check(300, 24, 4, 0, 64, 20, 1'b1);
        chk(lane_err == 1'b0, "R9 error cleared", lane_err, 0);

        // R10 start in the done cycle is dropped
        issue(1920, 24, 4, 2, 64, 10, ok);
        hw = words_per_line; hl = lane_word_count; hwt = line_wait;
        chk(hw == exp_words(1920, 24), "R1 before collision", hw, exp_words(1920, 24));
        chk(hwt == 18, "R8 before collision", hwt, 18);
        pix_count = 16'd7; bits_pp = 6'd8; lane_cnt = 3'd1; tu_min_bytes = 8'd2;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b0, "R10 start in done cycle ignored (busy)", busy, 0);
        chk(done == 1'b0, "R11 no extra done", done, 0);
        repeat (20) @(posedge clk);
        #1;
        chk(busy == 1'b0 && done == 1'b0, "R10 no hidden run", {busy, done}, 0);
        chk(words_per_line == 18'(hw) && lane_word_count == 18'(hl) && line_wait == 8'(hwt),
            "R10 results held", line_wait, hwt);

        // R10 start while running is ignored
        @(posedge clk); #1;
        pix_count = 16'd64; bits_pp = 6'd16; lane_cnt = 3'd2; color_fmt = 2'd0;
        tu_len = 7'd64; tu_min_bytes = 8'd30;
        start = 1'b1;
        @(posedge clk); #1;
        pix_count = 16'd1; bits_pp = 6'd1;
        @(posedge clk); #1;
        start = 1'b0;
        while (!done && busy) begin
            @(posedge clk); #1;
        end
        chk(words_per_line == 18'(64), "R10 mid-run start ignored", words_per_line, 64);
        chk(line_wait == 8'(34), "R6 mid-run wait", line_wait, 34);

        finish_run();
    end
endmodule